// File: doc/BRIEF.md
# Burst Column Address Generator

This block supplies the column address for every beat of a DRAM read or write burst. When an access begins, a start pulse loads the 8-bit starting column and a 3-bit burst length code. From the next cycle the block presents one column per clock and flags each cycle that carries a beat. A done pulse marks the final beat. Bursts of 2, 4 or 8 beats step through their columns in sequential order and wrap inside the aligned block that holds the starting column. A full-page burst walks the whole 256-column row, wraps around, and continues until a terminate input stops it.

A start pulse may arrive on any clock, even while a burst is running. The running burst is then abandoned and a new one begins from the new column with the new length. The memory controller upstream uses the column output and the beat flag to drive the column address bus. It uses done to schedule the next command.

Top module: `burst_col_gen`

## Requirements
- R1: After reset, beat_valid and done are 0 and col is 0.
- R2: On the cycle after start is high at a clock edge, col equals the start_col sampled at that edge and beat_valid is 1.
- R3: Length codes 0, 1, 2 and 3 give bursts of exactly 1, 2, 4 and 8 beats, one column per clock, with beat_valid high on each beat and low on the cycle after the last beat.
- R4: For bursts of 2, 4 and 8 beats, the low 1, 2 or 3 bits of col count up by one each beat and wrap to zero, while the bits above them keep the starting value.
- R5: Length codes 4, 5 and 6 behave as code 0 (a single beat).
- R6: Length code 7 is a full-page burst. col counts up by one each beat, wraps from 255 to 0, and the burst does not end and raises no done pulse until it is terminated.
- R7: done is high for exactly one cycle, in the same cycle as the last beat of a fixed-length burst. beat_valid is low on the following cycle unless a new start was given.
- R8: When term is high during a beat, done is high in that cycle and the burst ends, so beat_valid is low on the next cycle. When term is high and no burst is running, it has no effect: done and beat_valid stay 0.
- R9: A start given during a running burst abandons that burst and restarts from the new column with the new length. When start and term are high together, start takes priority and the new burst runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a burst, or restart one, from start_col |
| start_col | input | 8 | Starting column address |
| len_code | input | 3 | Burst length: 0=1, 1=2, 2=4, 3=8, 7=full page, others=1 |
| term | input | 1 | Terminate the running burst |
| col | output | 8 | Column address of the current beat |
| beat_valid | output | 1 | col carries a burst beat this cycle |
| done | output | 1 | Last beat of the burst, or terminate accepted |

## Verification
The hardest cases to reach are the mid-burst overlaps: a restart that lands partway through an 8-beat burst, a start that coincides with a terminate, and a full-page burst that crosses column 255. Directed sequences place start and term on chosen beats counted from the previous start. A full-page burst is launched a few columns below the top of the row, so the wrap and the later terminate both occur within a short run. Each of these results is checked against columns computed in the bench.

// File: rtl/burst_col_gen.sv
module burst_col_gen #(
  parameter int COL_W  = 8,
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [COL_W-1:0]  start_col,
  input  logic [CODE_W-1:0] len_code,
  input  logic              term,
  output logic [COL_W-1:0]  col,
  output logic              beat_valid,
  output logic              done
);
  localparam int BLK_W = 3;
  localparam logic [CODE_W-1:0] PAGE_CODE = CODE_W'(7);

  logic [COL_W-1:0] col_q, mask_q, mask_d, col_nxt;
  logic [BLK_W-1:0] cnt_q;
  logic             valid_q, page_q, last;

  always_comb begin
    case (len_code)
      CODE_W'(1): mask_d = COL_W'(1);
      CODE_W'(2): mask_d = COL_W'(3);
      CODE_W'(3): mask_d = COL_W'(7);
      PAGE_CODE:  mask_d = '1;
      default:    mask_d = '0;
    endcase
  end

  assign col_nxt = (col_q & ~mask_q) | ((col_q + COL_W'(1)) & mask_q);
  assign last    = valid_q & ~page_q & (cnt_q == mask_q[BLK_W-1:0]);
  assign done    = valid_q & (last | term);

  assign col        = col_q;
  assign beat_valid = valid_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col_q   <= '0;
      mask_q  <= '0;
      cnt_q   <= '0;
      valid_q <= 1'b0;
      page_q  <= 1'b0;
    end else if (start) begin
      col_q   <= start_col;
      mask_q  <= mask_d;
      cnt_q   <= '0;
      valid_q <= 1'b1;
      page_q  <= (len_code == PAGE_CODE);
    end else if (done) begin
      valid_q <= 1'b0;
    end else if (valid_q) begin
      col_q <= col_nxt;
      cnt_q <= cnt_q + BLK_W'(1);
    end
  end

  AST_LOAD_COLUMN: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (beat_valid && col == $past(start_col))); // R2
  AST_DONE_ON_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> beat_valid); // R7
  AST_END_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> !beat_valid); // R8
  AST_STEP_EACH_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !done && !start) |=> (beat_valid && col[0] != $past(col[0]))); // R3
  AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !done && !start && !page_q) |=> (col[COL_W-1:BLK_W] == $past(col[COL_W-1:BLK_W]))); // R4
  AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (!beat_valid && !start) |=> (!beat_valid && !done)); // R8
endmodule

// File: tb/burst_col_gen_test.sv
module burst_col_gen_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [7:0] start_col = '0;
  logic [2:0] len_code = '0;
  logic       term = 1'b0;
  logic [7:0] col;
  logic       beat_valid, done;
  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  burst_col_gen uut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col),
    .len_code(len_code), .term(term), .col(col), .beat_valid(beat_valid), .done(done)
  );

  // start column, length code, expected beat count
  typedef struct packed { logic [7:0] sc; logic [2:0] code; logic [8:0] nb; } vec_t;
  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{8'h35, 3'd0, 9'd1}, '{8'h35, 3'd1, 9'd2}, '{8'h36, 3'd2, 9'd4},
    '{8'h3D, 3'd3, 9'd8}, '{8'hF0, 3'd4, 9'd1}, '{8'h07, 3'd5, 9'd1},
    '{8'hAA, 3'd6, 9'd1}, '{8'hFF, 3'd3, 9'd8}, '{8'h00, 3'd2, 9'd4},
    '{8'h81, 3'd1, 9'd2}};

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // set inputs at negedge, sample outputs 1ns later
  task automatic cyc(logic s, logic [7:0] c, logic [2:0] l, logic t);
    @(negedge clk);
    start = s; start_col = c; len_code = l; term = t;
    #1;
  endtask

  function automatic logic [7:0] wcol(logic [7:0] sc, int nb, int i);
    int m = nb - 1;
    return (sc & ~8'(m)) | (8'(int'(sc) + i) & 8'(m));
  endfunction

  initial begin
    #2_000_000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    cyc(0, 0, 0, 0); cyc(0, 0, 0, 0);
    chk("R1 valid", beat_valid, 0); chk("R1 done", done, 0); chk("R1 col", col, 0);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      cyc(1, VEC[v].sc, VEC[v].code, 0);
      for (int i = 0; i < int'(VEC[v].nb); i++) begin
        cyc(0, 0, 0, 0);
        chk("R2/R3 valid", beat_valid, 1);
        chk("R4/R5 col", col, wcol(VEC[v].sc, int'(VEC[v].nb), i));
        chk("R7 done", done, (i == int'(VEC[v].nb) - 1));
      end
      cyc(0, 0, 0, 0);
      chk("R3 end valid", beat_valid, 0); chk("R7 single pulse", done, 0);
    end

    // R6 full page wraps past 255, no done, then terminate
    cyc(1, 8'hFD, 3'd7, 0);
    for (int i = 0; i < 12; i++) begin
      cyc(0, 0, 0, 0);
      chk("R6 col", col, 8'(8'hFD + i)); chk("R6 no done", done, 0);
    end
    cyc(0, 0, 0, 1);
    chk("R8 term col", col, 8'h09); chk("R8 term done", done, 1);
    cyc(0, 0, 0, 0);
    chk("R8 ends", beat_valid, 0);

    // R8 term while idle is ignored
    cyc(0, 0, 0, 1);
    chk("R8 idle done", done, 0);
    cyc(0, 0, 0, 0);
    chk("R8 idle valid", beat_valid, 0);

    // R8 term mid fixed burst
    cyc(1, 8'h20, 3'd2, 0);
    cyc(0, 0, 0, 0); chk("R8 beat0", col, 8'h20);
    cyc(0, 0, 0, 1); chk("R8 beat1", col, 8'h21); chk("R8 early done", done, 1);
    cyc(0, 0, 0, 0); chk("R8 cut", beat_valid, 0);

    // R9 restart mid 8-beat burst
    cyc(1, 8'h10, 3'd3, 0);
    cyc(0, 0, 0, 0); chk("R9 a0", col, 8'h10);
    cyc(0, 0, 0, 0); chk("R9 a1", col, 8'h11);
    cyc(1, 8'h47, 3'd2, 0); chk("R9 a2", col, 8'h12); chk("R9 no done", done, 0);
    for (int i = 0; i < 4; i++) begin
      cyc(0, 0, 0, 0);
      chk("R9 new col", col, wcol(8'h47, 4, i)); chk("R9 new done", done, (i == 3));
    end
    cyc(0, 0, 0, 0); chk("R9 new end", beat_valid, 0);

    // R9 start with term: start wins
    cyc(1, 8'h50, 3'd3, 0);
    cyc(0, 0, 0, 0); chk("R9 b0", col, 8'h50);
    cyc(1, 8'hC2, 3'd1, 1); chk("R9 term done", done, 1);
    cyc(0, 0, 0, 0); chk("R9 prio valid", beat_valid, 1); chk("R9 prio col", col, 8'hC2);
    cyc(0, 0, 0, 0); chk("R9 prio col2", col, 8'hC3); chk("R9 prio done", done, 1);
    cyc(0, 0, 0, 0); chk("R9 prio end", beat_valid, 0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule